// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave on a Two-Wire Bus

This block is a two-wire serial bus target that holds the configuration bytes of a clock generator. It answers only to the 7-bit address 0x69. On the wire, that address appears as 0xD2 for a write and 0xD3 for a read. The block keeps no register pointer, so every transfer begins at byte 0.

A write is laid out as follows:
- After the address, the controller sends two bytes, a command code and a length. The block acknowledges both and discards them.
- The data bytes that follow land in byte 0, byte 1 and so on, in ascending order.
- The controller may end the transfer with STOP after any whole byte.

A read is laid out as follows:
- The block first returns a length byte.
- It then returns the stored bytes in ascending order.
- Selected bit positions of the read data come from a read-only status input instead of from storage.

Both bus lines are open-drain. The block takes input samples of both lines and drives a pull-low enable for each. The pull-low enable for SCL is never raised. The line samples pass through a synchronizer and a glitch filter before any edge is detected. The stored bytes are presented in parallel on `cfg_o` for the clock generator to use.

Top module: `cfg_i2c_slave`

## Requirements
- R1: Address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address byte gets no acknowledge, and the bytes that follow it up to the next START have no effect on `cfg_o`.
- R2: On a write, the two bytes that follow the address are acknowledged and their values are discarded. `cfg_o` is unchanged after a write that carries only these two bytes.
- R3: The data bytes of a write go to byte 0, 1, 2 and so on, in that order. Byte k appears on `cfg_o[8k+7:8k]`. Every data byte is acknowledged.
- R4: STOP may follow any complete data byte. Bytes received before the STOP hold their new values, and all later bytes keep their previous values.
- R5: A byte cut off by STOP or by a repeated START before its 8th bit is discarded. A byte is committed on the SCL rising edge of its 8th bit.
- R6: A read returns the length byte 0x07 first, then bytes 0 to 6, then 0x00 for every further byte the controller asks for.
- R7: In read data, each bit whose `STATUS_MASK` bit is 1 is taken from `status_i`. The default mask is `cfg_o` bits 53:50, which are bits 5:2 of byte 6. Writes to those positions are still stored and appear on `cfg_o`.
- R8: After the controller NACKs a read byte, the block keeps SDA released through every following SCL clock until START or STOP.
- R9: Data bytes sent beyond byte 6 are acknowledged and have no effect on `cfg_o`.
- R10: A pulse on SCL or SDA that lasts less than `FILT_LEN` system clocks after synchronization is ignored.
- R11: Reset does three things: it loads `cfg_o` with `CFG_DEFAULT` (byte 0 = 0x02, bytes 1 to 5 = 0xFF, byte 6 = 0x00), it releases SDA, and it keeps SCL released. The block never pulls SCL low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe_o | output | 1 | Pull-low enable for SCL (always 0) |
| sda_oe_o | output | 1 | Pull-low enable for SDA |
| status_i | input | 56 | Read-only status bits merged into read data |
| cfg_o | output | 56 | Stored configuration bytes, byte k at bits 8k+7:8k |

## Verification
The hardest situations to reach from the ports are the ones where the controller breaks off mid-byte, and a read after a NACK.

For the mid-byte cases, the bench drives individual bits rather than whole bytes. It then issues STOP or a repeated START after three to five bits and compares `cfg_o` against its own model.

For the NACK case, the bench first stores a byte 0 whose top bit is 0. Any wrongly driven next byte would then pull SDA low at once. The bench keeps clocking SCL after the NACK and samples the SDA enable in every high phase.

Glitch rejection is shown by injecting a one-clock SCL pulse in the middle of an address byte and a data byte. The check is that the acknowledge still lands on the 9th clock and that the data is stored intact.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_W_BYTE,
      ST_W_ACK,
      ST_R_BYTE,
      ST_R_ACK,
      ST_DONE
   } bus_state_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   assign sync_out = sync_q[SYNC_STAGES-1];

   if (FILT_LEN <= 1) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_o <= 1'b1;
         else        line_o <= sync_out;
      end
   end else begin : g_count
      logic [CW-1:0] run_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_o  <= 1'b1;
            run_cnt <= '0;
         end else if (sync_out == line_o) begin
            run_cnt <= '0;
         end else if (run_cnt == CW'(FILT_LEN - 1)) begin
            line_o  <= sync_out;
            run_cnt <= '0;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end

      // R10
      filt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(line_o) |-> ($past(sync_out) == line_o && $past(sync_out, 2) == line_o));
   end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
   parameter int                      NUM_BYTES   = 7,
   parameter logic [NUM_BYTES*8-1:0]  CFG_DEFAULT = '0,
   parameter logic [NUM_BYTES*8-1:0]  STATUS_MASK = '0,
   parameter int                      BIDX_W      = $clog2(NUM_BYTES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [BIDX_W-1:0]        wr_idx,
   input  logic [7:0]               wr_data,
   input  logic [NUM_BYTES*8-1:0]   status_i,
   output logic [NUM_BYTES*8-1:0]   cfg_o,
   output logic [NUM_BYTES*8-1:0]   view_o
);

   logic [NUM_BYTES-1:0] hit_vec;

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
      logic [7:0] byte_q;

      assign hit_vec[b] = wr_en && (wr_idx == BIDX_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          byte_q <= CFG_DEFAULT[b*8 +: 8];
         else if (hit_vec[b]) byte_q <= wr_data;
      end

      assign cfg_o[b*8 +: 8] = byte_q;
   end

   assign view_o = (cfg_o & ~STATUS_MASK) | (status_i & STATUS_MASK);

   // R3
   one_byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R4
   untouched_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_o));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
   import cfg_i2c_pkg::*;
#(
   parameter int                      NUM_BYTES   = 7,
   parameter logic [6:0]              DEV_ADDR    = 7'h69,
   parameter int                      SYNC_STAGES = 2,
   parameter int                      FILT_LEN    = 3,
   parameter logic [NUM_BYTES*8-1:0]  CFG_DEFAULT = 56'h00_FF_FF_FF_FF_FF_02,
   parameter logic [NUM_BYTES*8-1:0]  STATUS_MASK = 56'h3C_00_00_00_00_00_00
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl_i,
   input  logic                     sda_i,
   output logic                     scl_oe_o,
   output logic                     sda_oe_o,
   input  logic [NUM_BYTES*8-1:0]   status_i,
   output logic [NUM_BYTES*8-1:0]   cfg_o
);

   localparam int REG_W  = NUM_BYTES * 8;
   localparam int CNT_W  = $clog2(NUM_BYTES + 4);
   localparam int BIDX_W = $clog2(NUM_BYTES);
   localparam logic [CNT_W-1:0] IDX_MAX = CNT_W'(NUM_BYTES + 2);

   if (NUM_BYTES < 2 || NUM_BYTES > 255) begin : g_bad_bytes
      $error("NUM_BYTES must lie in 2..255");
   end

   // line conditioning
   logic scl_f, sda_f, scl_d, sda_d;

   i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));

   i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   logic scl_rise, scl_fall, start_evt, stop_evt;
   assign scl_rise  = scl_f & ~scl_d;
   assign scl_fall  = ~scl_f & scl_d;
   assign start_evt = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_evt  = scl_f & scl_d & ~sda_d & sda_f;

   // protocol state
   bus_state_t       state;
   logic [7:0]       shreg, tx;
   logic [3:0]       bitcnt;
   logic [CNT_W-1:0] idx, rd_sel;
   logic             acked;
   logic [REG_W-1:0] view;
   logic [7:0]       rd_byte;
   logic             wr_en;
   logic [7:0]       wr_data;
   logic [BIDX_W-1:0] wr_idx;

   assign wr_data = {shreg[6:0], sda_f};
   assign wr_en   = (state == ST_W_BYTE) && scl_rise && (bitcnt == 4'd7) &&
                    (idx >= CNT_W'(2)) && (idx < IDX_MAX);
   assign wr_idx  = BIDX_W'(idx - CNT_W'(2));

   cfg_reg_bank #(
      .NUM_BYTES(NUM_BYTES), .CFG_DEFAULT(CFG_DEFAULT),
      .STATUS_MASK(STATUS_MASK), .BIDX_W(BIDX_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .status_i(status_i), .cfg_o(cfg_o), .view_o(view));

   always_comb begin
      rd_sel  = (state == ST_R_ACK) ? idx + 1'b1 : idx;
      rd_byte = 8'h00;
      if (rd_sel == '0) rd_byte = 8'(NUM_BYTES);
      for (int b = 0; b < NUM_BYTES; b++) begin
         if (rd_sel == CNT_W'(b + 1)) rd_byte = view[b*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         shreg    <= '0;
         tx       <= '0;
         bitcnt   <= '0;
         idx      <= '0;
         acked    <= 1'b0;
         sda_oe_o <= 1'b0;
      end else if (start_evt) begin
         state    <= ST_ADDR;
         bitcnt   <= '0;
         sda_oe_o <= 1'b0;
      end else if (stop_evt) begin
         state    <= ST_IDLE;
         sda_oe_o <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR: begin
               if (scl_rise) begin
                  shreg  <= wr_data;
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  if (shreg[7:1] == DEV_ADDR) begin
                     state    <= ST_ADDR_ACK;
                     sda_oe_o <= 1'b1;
                     idx      <= '0;
                  end else begin
                     state <= ST_DONE;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (shreg[0]) begin
                     state    <= ST_R_BYTE;
                     tx       <= rd_byte;
                     sda_oe_o <= ~rd_byte[7];
                  end else begin
                     state    <= ST_W_BYTE;
                     sda_oe_o <= 1'b0;
                  end
               end
            end
            ST_W_BYTE: begin
               if (scl_rise) begin
                  shreg  <= wr_data;
                  bitcnt <= bitcnt + 1'b1;
                  if (bitcnt == 4'd7 && idx != IDX_MAX) idx <= idx + 1'b1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  state    <= ST_W_ACK;
                  sda_oe_o <= 1'b1;
                  bitcnt   <= '0;
               end
            end
            ST_W_ACK: begin
               if (scl_fall) begin
                  state    <= ST_W_BYTE;
                  sda_oe_o <= 1'b0;
               end
            end
            ST_R_BYTE: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     state    <= ST_R_ACK;
                     sda_oe_o <= 1'b0;
                  end else begin
                     tx       <= {tx[6:0], 1'b0};
                     sda_oe_o <= ~tx[6];
                  end
               end
            end
            ST_R_ACK: begin
               if (scl_rise) begin
                  acked <= ~sda_f;
               end else if (scl_fall) begin
                  if (acked) begin
                     state    <= ST_R_BYTE;
                     bitcnt   <= '0;
                     tx       <= rd_byte;
                     sda_oe_o <= ~rd_byte[7];
                     if (idx != IDX_MAX) idx <= idx + 1'b1;
                  end else begin
                     state <= ST_DONE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign scl_oe_o = 1'b0;

   // R8
   sda_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe_o |-> (state == ST_ADDR_ACK || state == ST_W_ACK || state == ST_R_BYTE));

   // R1
   addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_ADDR_ACK) |-> (shreg[7:1] == DEV_ADDR));

   // R5
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (state == ST_IDLE && !sda_oe_o));

   // R6
   count_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_ADDR_ACK && state == ST_R_BYTE) |-> (tx == 8'(NUM_BYTES)));

   // R11
   scl_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= 4'd8 && !scl_oe_o);

endmodule

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;

   localparam int          NB   = 7;
   localparam logic [55:0] DEF  = 56'h00_FF_FF_FF_FF_FF_02;
   localparam logic [55:0] MASK = 56'h3C_00_00_00_00_00_00;
   localparam int          Q    = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic [55:0] status = '0;
   logic        scl_oe, sda_oe;
   logic [55:0] cfg;
   logic        scl_line, sda_line;

   always #4 clk = ~clk;

   assign scl_line = m_scl & ~scl_oe;
   assign sda_line = m_sda & ~sda_oe;

   cfg_i2c_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .status_i(status), .cfg_o(cfg));

   int          checks = 0;
   int          fails = 0;
   bit          finished = 1'b0;
   logic [55:0] exp_cfg;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      wclk(2); m_sda = 1'b1; wclk(2*Q);
      m_scl = 1'b1; wclk(2*Q);
      m_sda = 1'b0; wclk(2*Q);
      m_scl = 1'b0;
   endtask

   task automatic bus_stop();
      wclk(2); m_sda = 1'b0; wclk(2*Q);
      m_scl = 1'b1; wclk(2*Q);
      m_sda = 1'b1; wclk(2*Q);
   endtask

   task automatic send_bit(input logic b, input bit glitch);
      wclk(2); m_sda = b; wclk(Q - 2);
      if (glitch) begin
         m_scl = 1'b1; wclk(1); m_scl = 1'b0;
      end
      wclk(Q);
      m_scl = 1'b1; wclk(2*Q);
      m_scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input int gbit, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i], i == gbit);
      wclk(2); m_sda = 1'b1; wclk(2*Q - 2);
      m_scl = 1'b1; wclk(Q);
      ack = ~sda_line; wclk(Q);
      m_scl = 1'b0;
   endtask

   task automatic recv_byte(input logic m_ack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         wclk(2); m_sda = 1'b1; wclk(2*Q - 2);
         m_scl = 1'b1; wclk(Q);
         d[i] = sda_line; wclk(Q);
         m_scl = 1'b0;
      end
      wclk(2); m_sda = ~m_ack; wclk(2*Q - 2);
      m_scl = 1'b1; wclk(2*Q);
      m_scl = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int j, input int k);
      return 8'(((j + 1) << 4) | k);
   endfunction

   // write header (address, command, length); n data bytes; STOP
   task automatic write_n(input int n, input int k, input string req);
      logic ack;
      bus_start();
      send_byte(8'hD2, -1, ack); chk({req, " R1 write address ack"}, ack, 1);
      send_byte(8'(k * 37), -1, ack); chk("R2 command ack", ack, 1);
      send_byte(8'(255 - k), -1, ack); chk("R2 length ack", ack, 1);
      for (int j = 0; j < n; j++) begin
         send_byte(pat(j, k), -1, ack);
         chk(j < NB ? {req, " R3 data ack"} : "R9 extra byte ack", ack, 1);
         if (j < NB) exp_cfg[j*8 +: 8] = pat(j, k);
      end
      bus_stop();
      wclk(4);
   endtask

   task automatic read_all(input string req);
      logic       ack;
      logic [7:0] d;
      logic [55:0] merged;
      merged = (exp_cfg & ~MASK) | (status & MASK);
      bus_start();
      send_byte(8'hD3, -1, ack); chk("R1 read address ack", ack, 1);
      recv_byte(1'b1, d); chk("R6 length byte", d, 8'h07);
      for (int j = 0; j < NB + 2; j++) begin
         recv_byte(j < NB + 1, d);
         chk({req, " read byte"}, d, j < NB ? merged[j*8 +: 8] : 8'h00);
      end
      bus_stop();
      wclk(4);
   endtask

   initial begin
      logic       ack;
      logic [7:0] d;
      exp_cfg = DEF;
      wclk(10);
      rst_n = 1'b1;
      wclk(10);
      // R11 reset state
      chk("R11 reset cfg", cfg, DEF);
      chk("R11 reset sda release", sda_oe, 0);
      chk("R11 scl never driven", scl_oe, 0);

      // R1 foreign address
      bus_start();
      send_byte(8'hA0, -1, ack); chk("R1 foreign address nack", ack, 0);
      send_byte(8'h00, -1, ack);
      send_byte(8'h00, -1, ack);
      send_byte(8'h99, -1, ack);
      bus_stop(); wclk(4);
      chk("R1 foreign address no effect", cfg, exp_cfg);

      // R2 header only
      write_n(0, 3, "R2");
      chk("R2 header-only write leaves cfg", cfg, exp_cfg);

      // R3/R4/R9 sweep over STOP position
      for (int k = 1; k <= NB + 2; k++) begin
         if (k == NB + 1) continue;
         write_n(k, k, k == NB ? "R3" : (k > NB ? "R9" : "R4"));
         chk(k == NB ? "R3 full write" : (k > NB ? "R9 extra dropped" : "R4 stop after byte"),
             cfg, exp_cfg);
      end

      // R8 NACK during read: byte 0 top bit is 0
      bus_start();
      send_byte(8'hD3, -1, ack); chk("R1 read address ack", ack, 1);
      recv_byte(1'b0, d); chk("R6 length byte before nack", d, 8'h07);
      for (int i = 0; i < 9; i++) begin
         wclk(2); m_sda = 1'b1; wclk(2*Q - 2);
         m_scl = 1'b1; wclk(Q);
         chk("R8 sda released after nack", sda_oe, 0);
         wclk(Q); m_scl = 1'b0;
      end
      bus_stop(); wclk(4);

      // R6/R7 read with status merge
      status = 56'hA5_A5_A5_A5_A5_A5_A5;
      read_all("R7");
      status = 56'h5A_00_00_00_00_00_00;
      read_all("R6");
      chk("R7 cfg keeps stored bits", cfg, exp_cfg);

      // R5 STOP after partial byte
      bus_start();
      send_byte(8'hD2, -1, ack);
      send_byte(8'h00, -1, ack);
      send_byte(8'h00, -1, ack);
      send_byte(8'hAA, -1, ack); exp_cfg[7:0] = 8'hAA;
      for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
      bus_stop(); wclk(4);
      chk("R5 stop mid-byte", cfg, exp_cfg);

      // R5 repeated START after partial byte
      bus_start();
      send_byte(8'hD2, -1, ack);
      send_byte(8'h00, -1, ack);
      send_byte(8'h00, -1, ack);
      for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
      bus_start();
      send_byte(8'hA0, -1, ack); chk("R1 foreign after restart", ack, 0);
      bus_stop(); wclk(4);
      chk("R5 restart mid-byte", cfg, exp_cfg);

      // R10 glitches on SCL
      bus_start();
      send_byte(8'hD2, 4, ack); chk("R10 ack despite scl glitch", ack, 1);
      send_byte(8'h12, -1, ack);
      send_byte(8'h34, -1, ack);
      send_byte(8'h5C, 2, ack); chk("R10 data ack despite glitch", ack, 1);
      exp_cfg[7:0] = 8'h5C;
      bus_stop(); wclk(4);
      chk("R10 glitched byte stored intact", cfg, exp_cfg);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule